// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block carries out the entry phase of an interrupt for an 8-bit processor core that has three request inputs. The first is a non-maskable request that acts on its rising edge. The second is a fast maskable request. The third is a normal maskable request. At an instruction boundary the block looks at the pending requests and at the mask bits of the condition-code byte, and picks one winner. It then writes the saved registers byte by byte through a simple memory port while it walks the stack pointer downward. It reads the 16-bit handler address from a fixed vector location. When it finishes, it returns the new PC, the new condition code and the final stack pointer, together with a cycle charge and a one-cycle acknowledge that carries a source code.

The fast request saves only a short frame. Every other entry saves the whole register set. An optional extended-register mode adds one more word to the full frame. A second mode bit turns fast entries into full saves. If a wait instruction has already stacked the state, the next entry skips every write and charges a small fixed cost. A synchronise-wait flag is released whenever a maskable request line is high, even when that request is masked.

The core must hold its register inputs and `cc_in` steady from the start of an entry until `ack`. On `ack` it takes `pc_out`, `cc_out` and `sp_out`.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable request is taken only on a low-to-high transition of `nmi_req`. Holding the line high, or lowering it, starts nothing more. Any transition seen before the first `sp_load` pulse after reset is discarded, including a line that is already high when the block is armed.
- R2: Priority is non-maskable, then fast, then normal. The fast request is eligible only while `cc_in` bit 6 (fast mask) is 0. The normal request is eligible only while `cc_in` bit 4 (normal mask) is 0. A request that is masked is not taken.
- R3: A short entry writes, in this order, PC low, PC high, then the condition byte with bit 7 (whole-frame flag) cleared. It charges 10 cycles. The fast vector is at 0xFFF6.
- R4: A full entry sets bit 7 of the saved condition byte. It writes PC, U, Y and X as words, then DP, B, A, and last the condition byte. It charges 19 cycles. The non-maskable vector is at 0xFFFC and the normal vector is at 0xFFF8.
- R5: Each write goes to the stack pointer minus one and then moves it down by one, so the first byte lands at `sp_in`-1. Every word is written low byte first. `sp_out` equals `sp_in` minus the number of bytes written.
- R6: Non-maskable and fast entries set both bit 4 and bit 6 in `cc_out`. A normal entry sets bit 4 and leaves bit 6 as it was.
- R7: After a `wai_enter` pulse, the next entry writes nothing, charges 7 cycles, leaves the stack pointer and bit 7 unchanged, and clears `wai_pending`.
- R8: `sync_wait` is set by `sync_enter`. It is cleared in the cycle after either maskable request line is high, whatever the masks say, and it is also cleared by a non-maskable entry.
- R9: With `ext_mode` set, a full entry writes the extra word (low byte, then high byte) after DP and before B, and the charge rises by 2.
- R10: With `fast_full` set, a fast entry does a full save with bit 7 set and the full charge. It still uses the fast vector and sets both masks.
- R11: The vector is read as a high byte at the vector address and a low byte at the next address. `ack` then pulses for one cycle together with `pc_we`, `cc_we` and `sp_we`. The `ack_src` code is 1 for non-maskable, 2 for fast and 3 for normal.
- R12: Each memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle in which `mem_ack` is high. Out of reset the port is idle.
- R13: An entry starts only while the sequencer is idle and `insn_boundary` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| nmi_req | input | 1 | Non-maskable request, edge acting |
| fast_req | input | 1 | Fast maskable request, level |
| norm_req | input | 1 | Normal maskable request, level |
| sp_load | input | 1 | Pulse: core has loaded the stack pointer |
| sync_enter | input | 1 | Pulse: core enters synchronise wait |
| wai_enter | input | 1 | Pulse: wait instruction has stacked the state |
| ext_mode | input | 1 | Full frames include the extra word |
| fast_full | input | 1 | Fast entries perform a full save |
| cc_in | input | 8 | Current condition code (bit 7 frame flag, bit 6 fast mask, bit 4 normal mask) |
| pc_in | input | 16 | Return address to save |
| u_in | input | 16 | User stack pointer to save |
| y_in | input | 16 | Index Y to save |
| x_in | input | 16 | Index X to save |
| w_in | input | 16 | Extra word to save in extended mode |
| sp_in | input | 16 | Stack pointer at entry start |
| dp_in | input | 8 | Direct-page byte to save |
| b_in | input | 8 | Accumulator B to save |
| a_in | input | 8 | Accumulator A to save |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a stack write, 0 for a vector read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this clock edge |
| pc_out | output | 16 | Handler address |
| pc_we | output | 1 | Load `pc_out` |
| cc_out | output | 8 | New condition code |
| cc_we | output | 1 | Load `cc_out` |
| sp_out | output | 16 | Stack pointer after the writes |
| sp_we | output | 1 | Load `sp_out` |
| cycles_out | output | 5 | Cycle charge of the entry, valid with `ack` |
| ack | output | 1 | One-cycle entry-complete pulse |
| ack_src | output | 2 | Source of the completed entry |
| sync_wait | output | 1 | Synchronise-wait flag |
| wai_pending | output | 1 | State already stacked by a wait instruction |

## Verification
Some rules are checked by assertions on every cycle. Memory requests must stay steady until acknowledged. Consecutive stack writes must step down by exactly one address. The acknowledge must be a single pulse carrying the normal mask, and the fast mask as well for non-maskable and fast sources. A wait-stacked entry must never write. The synchronise flag must drop after a maskable line is seen. A pending non-maskable request implies the block is armed, and the sequencer must not leave idle without a boundary. Other properties can only be shown by the bench scenarios: the exact byte order and contents of each frame, the saved frame flag, the cycle charges in each mode, the vector-derived PC, priority under simultaneous requests, and the discarding of early or level-held non-maskable requests.

// File: rtl/irq_seq_pkg.sv
// Shared types and constants of the interrupt entry sequencer.
// Assumes a byte-wide memory port and two-byte words.
package irq_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SLOT_W = 4;

    // condition-code bit positions that the core decodes
    localparam int CC_E_BIT = 7;
    localparam int CC_F_BIT = 6;
    localparam int CC_I_BIT = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_NORM = 2'd3
    } irq_src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VHI,
        ST_VLO,
        ST_DONE
    } seq_state_e;

    // full frame in write order; the short frame uses PCL, PCH, CC
    typedef enum logic [SLOT_W-1:0] {
        SL_PCL, SL_PCH, SL_UL, SL_UH, SL_YL, SL_YH, SL_XL, SL_XH,
        SL_DP, SL_WL, SL_WH, SL_B, SL_A, SL_CC
    } slot_e;

    localparam int LAST_SHORT = 2;
    localparam int LAST_EXT   = int'(SL_CC);
    localparam int LAST_FULL  = LAST_EXT - 2;
    localparam int EXT_FIRST  = int'(SL_WL);
endpackage

// File: rtl/irq_arbiter.sv
// Request arbiter: detects non-maskable edges once armed, holds the
// synchronise and wait flags, and picks the winning source.
// Assumes cc_in is the live condition code from the core.
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              can_start,
    input  logic              nmi_req,
    input  logic              fast_req,
    input  logic              norm_req,
    input  logic              sp_load,
    input  logic              sync_enter,
    input  logic              wai_enter,
    input  logic [BYTE_W-1:0] cc_in,
    output logic              start,
    output irq_src_e          win_src,
    output logic              waited,
    output logic              sync_wait,
    output logic              wai_pending
);
    logic nmi_last_q;
    logic armed_q;
    logic nmi_pend_q;
    logic sync_q;
    logic wai_q;
    logic nmi_rise;

    assign nmi_rise = nmi_req & ~nmi_last_q;

    // winner selection by fixed priority and masks
    always_comb begin
        if (nmi_pend_q)
            win_src = SRC_NMI;
        else if (fast_req && !cc_in[CC_F_BIT])
            win_src = SRC_FAST;
        else if (norm_req && !cc_in[CC_I_BIT])
            win_src = SRC_NORM;
        else
            win_src = SRC_NONE;
    end

    assign start       = can_start && (win_src != SRC_NONE);
    assign waited      = wai_q;
    assign sync_wait   = sync_q;
    assign wai_pending = wai_q;

    // edge capture, arming and wait-flag bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_last_q <= 1'b0;
            armed_q    <= 1'b0;
            nmi_pend_q <= 1'b0;
            sync_q     <= 1'b0;
            wai_q      <= 1'b0;
        end else begin
            nmi_last_q <= nmi_req;
            if (sp_load)
                armed_q <= 1'b1;
            if (nmi_rise && armed_q)
                nmi_pend_q <= 1'b1;
            else if (start && win_src == SRC_NMI)
                nmi_pend_q <= 1'b0;
            if (fast_req || norm_req || (start && win_src == SRC_NMI))
                sync_q <= 1'b0;
            else if (sync_enter)
                sync_q <= 1'b1;
            if (start)
                wai_q <= 1'b0;
            else if (wai_enter)
                wai_q <= 1'b1;
        end
    end

    p_nmi_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend_q |-> armed_q);

    p_sync_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_req || norm_req) |=> !sync_q);
endmodule

// File: rtl/irq_push_mux.sv
// Frame byte selector: maps a write index to the register byte for
// short, full and extended frames. Purely combinational.
module irq_push_mux
    import irq_seq_pkg::*;
(
    input  logic [SLOT_W-1:0] idx,
    input  logic              full,
    input  logic              ext,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] u,
    input  logic [WORD_W-1:0] y,
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] w,
    input  logic [BYTE_W-1:0] dp,
    input  logic [BYTE_W-1:0] b,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] cc,
    output logic [BYTE_W-1:0] byte_o
);
    slot_e slot;

    // index to logical slot for the frame variant
    always_comb begin
        if (!full)
            slot = (idx == SLOT_W'(0)) ? SL_PCL :
                   (idx == SLOT_W'(1)) ? SL_PCH : SL_CC;
        else if (ext || idx < SLOT_W'(EXT_FIRST))
            slot = slot_e'(idx);
        else
            slot = slot_e'(idx + SLOT_W'(2));
    end

    // slot to data byte
    always_comb begin
        case (slot)
            SL_PCL:  byte_o = pc[BYTE_W-1:0];
            SL_PCH:  byte_o = pc[WORD_W-1:BYTE_W];
            SL_UL:   byte_o = u[BYTE_W-1:0];
            SL_UH:   byte_o = u[WORD_W-1:BYTE_W];
            SL_YL:   byte_o = y[BYTE_W-1:0];
            SL_YH:   byte_o = y[WORD_W-1:BYTE_W];
            SL_XL:   byte_o = x[BYTE_W-1:0];
            SL_XH:   byte_o = x[WORD_W-1:BYTE_W];
            SL_DP:   byte_o = dp;
            SL_WL:   byte_o = w[BYTE_W-1:0];
            SL_WH:   byte_o = w[WORD_W-1:BYTE_W];
            SL_B:    byte_o = b;
            SL_A:    byte_o = a;
            default: byte_o = cc;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top: starts an entry chosen by the arbiter,
// writes the frame down the stack, reads the vector and reports results.
// Assumes register inputs and cc_in stay stable from start until ack.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] VEC_NMI     = 16'hFFFC,
    parameter logic [15:0] VEC_FAST    = 16'hFFF6,
    parameter logic [15:0] VEC_NORM    = 16'hFFF8,
    parameter int          CYC_W       = 5,
    parameter int          COST_SHORT  = 10,
    parameter int          COST_FULL   = 19,
    parameter int          COST_EXT    = 2,
    parameter int          COST_WAITED = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_boundary,
    input  logic              nmi_req,
    input  logic              fast_req,
    input  logic              norm_req,
    input  logic              sp_load,
    input  logic              sync_enter,
    input  logic              wai_enter,
    input  logic              ext_mode,
    input  logic              fast_full,
    input  logic [7:0]        cc_in,
    input  logic [15:0]       pc_in,
    input  logic [15:0]       u_in,
    input  logic [15:0]       y_in,
    input  logic [15:0]       x_in,
    input  logic [15:0]       w_in,
    input  logic [15:0]       sp_in,
    input  logic [7:0]        dp_in,
    input  logic [7:0]        b_in,
    input  logic [7:0]        a_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic [15:0]       pc_out,
    output logic              pc_we,
    output logic [7:0]        cc_out,
    output logic              cc_we,
    output logic [15:0]       sp_out,
    output logic              sp_we,
    output logic [CYC_W-1:0]  cycles_out,
    output logic              ack,
    output logic [1:0]        ack_src,
    output logic              sync_wait,
    output logic              wai_pending
);
    localparam logic [BYTE_W-1:0] MASK_E = BYTE_W'(1) << CC_E_BIT;
    localparam logic [BYTE_W-1:0] MASK_F = BYTE_W'(1) << CC_F_BIT;
    localparam logic [BYTE_W-1:0] MASK_I = BYTE_W'(1) << CC_I_BIT;

    seq_state_e        state_q;
    irq_src_e          src_q;
    irq_src_e          win_src;
    logic              start;
    logic              waited;
    logic              waited_q;
    logic              full_q;
    logic              ext_q;
    logic [SLOT_W-1:0] idx_q;
    logic [SLOT_W-1:0] last_q;
    logic [WORD_W-1:0] sp_q;
    logic [BYTE_W-1:0] cc_push_q;
    logic [BYTE_W-1:0] cc_new_q;
    logic [BYTE_W-1:0] vec_hi_q;
    logic [WORD_W-1:0] pc_q;
    logic [CYC_W-1:0]  cost_q;
    logic [WORD_W-1:0] vec_sel;
    logic [BYTE_W-1:0] push_byte;
    logic              start_full;
    logic              start_ext;
    logic [BYTE_W-1:0] start_mask;
    logic [BYTE_W-1:0] start_ccp;

    irq_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .can_start   ((state_q == ST_IDLE) && insn_boundary),
        .nmi_req     (nmi_req),
        .fast_req    (fast_req),
        .norm_req    (norm_req),
        .sp_load     (sp_load),
        .sync_enter  (sync_enter),
        .wai_enter   (wai_enter),
        .cc_in       (cc_in),
        .start       (start),
        .win_src     (win_src),
        .waited      (waited),
        .sync_wait   (sync_wait),
        .wai_pending (wai_pending)
    );

    irq_push_mux u_mux (
        .idx    (idx_q),
        .full   (full_q),
        .ext    (ext_q),
        .pc     (pc_in),
        .u      (u_in),
        .y      (y_in),
        .x      (x_in),
        .w      (w_in),
        .dp     (dp_in),
        .b      (b_in),
        .a      (a_in),
        .cc     (cc_push_q),
        .byte_o (push_byte)
    );

    // frame shape, masks and saved condition for the starting entry
    always_comb begin
        start_full = (win_src != SRC_FAST) || fast_full;
        start_ext  = start_full && ext_mode;
        start_mask = (win_src == SRC_NORM) ? MASK_I : (MASK_I | MASK_F);
        start_ccp  = start_full ? (cc_in | MASK_E) : (cc_in & ~MASK_E);
    end

    // vector address for the latched source
    always_comb begin
        case (src_q)
            SRC_NMI:  vec_sel = VEC_NMI;
            SRC_FAST: vec_sel = VEC_FAST;
            default:  vec_sel = VEC_NORM;
        endcase
    end

    // entry sequencing: start, frame writes, vector reads, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            src_q     <= SRC_NONE;
            waited_q  <= 1'b0;
            full_q    <= 1'b0;
            ext_q     <= 1'b0;
            idx_q     <= '0;
            last_q    <= '0;
            sp_q      <= '0;
            cc_push_q <= '0;
            cc_new_q  <= '0;
            vec_hi_q  <= '0;
            pc_q      <= '0;
            cost_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q     <= win_src;
                        waited_q  <= waited;
                        full_q    <= start_full;
                        ext_q     <= start_ext;
                        idx_q     <= '0;
                        sp_q      <= sp_in;
                        cc_push_q <= start_ccp;
                        if (waited) begin
                            cc_new_q <= cc_in | start_mask;
                            cost_q   <= CYC_W'(COST_WAITED);
                            state_q  <= ST_VHI;
                        end else begin
                            cc_new_q <= start_ccp | start_mask;
                            if (!start_full) begin
                                cost_q <= CYC_W'(COST_SHORT);
                                last_q <= SLOT_W'(LAST_SHORT);
                            end else if (start_ext) begin
                                cost_q <= CYC_W'(COST_FULL + COST_EXT);
                                last_q <= SLOT_W'(LAST_EXT);
                            end else begin
                                cost_q <= CYC_W'(COST_FULL);
                                last_q <= SLOT_W'(LAST_FULL);
                            end
                            state_q <= ST_PUSH;
                        end
                    end
                end
                ST_PUSH: begin
                    if (mem_ack) begin
                        sp_q <= sp_q - WORD_W'(1);
                        if (idx_q == last_q)
                            state_q <= ST_VHI;
                        else
                            idx_q <= idx_q + SLOT_W'(1);
                    end
                end
                ST_VHI: begin
                    if (mem_ack) begin
                        vec_hi_q <= mem_rdata;
                        state_q  <= ST_VLO;
                    end
                end
                ST_VLO: begin
                    if (mem_ack) begin
                        pc_q    <= {vec_hi_q, mem_rdata};
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // memory port driven from the state
    always_comb begin
        mem_req   = (state_q == ST_PUSH) || (state_q == ST_VHI) || (state_q == ST_VLO);
        mem_we    = (state_q == ST_PUSH);
        mem_wdata = push_byte;
        case (state_q)
            ST_PUSH: mem_addr = sp_q - WORD_W'(1);
            ST_VHI:  mem_addr = vec_sel;
            default: mem_addr = vec_sel + WORD_W'(1);
        endcase
    end

    // completion outputs
    always_comb begin
        ack        = (state_q == ST_DONE);
        pc_we      = ack;
        cc_we      = ack;
        sp_we      = ack;
        pc_out     = pc_q;
        cc_out     = cc_new_q;
        sp_out     = sp_q;
        cycles_out = cost_q;
        ack_src    = src_q;
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

    p_push_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
            (!(mem_req && mem_we) || mem_addr == $past(mem_addr) - 16'd1));

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ack_src != SRC_NONE));

    p_mask_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> cc_out[CC_I_BIT]);

    p_mask_f_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_src != SRC_NORM) |-> cc_out[CC_F_BIT]);

    p_waited_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (waited_q && state_q != ST_IDLE) |-> !(mem_req && mem_we));

    p_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !insn_boundary) |=> (state_q == ST_IDLE));
endmodule

// File: tb/irq_entry_seq_tb_top.sv
// Scoreboard bench: driver tasks queue expected writes, reads and
// completions; a negedge monitor models memory and compares results.
module irq_entry_seq_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, insn_boundary, nmi_req, fast_req, norm_req;
    logic        sp_load, sync_enter, wai_enter, ext_mode, fast_full;
    logic [7:0]  cc_r;
    logic [15:0] sp_r;
    logic [15:0] pc_v = 16'h1234, u_v = 16'h5678, y_v = 16'h9ABC;
    logic [15:0] x_v = 16'hDEF0, w_v = 16'h2468;
    logic [7:0]  dp_v = 8'h11, b_v = 8'h22, a_v = 8'h33;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, cc_out;
    logic        pc_we, cc_we, sp_we, ack, sync_wait, wai_pending;
    logic [4:0]  cycles_out;
    logic [1:0]  ack_src;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
        .nmi_req(nmi_req), .fast_req(fast_req), .norm_req(norm_req),
        .sp_load(sp_load), .sync_enter(sync_enter), .wai_enter(wai_enter),
        .ext_mode(ext_mode), .fast_full(fast_full), .cc_in(cc_r),
        .pc_in(pc_v), .u_in(u_v), .y_in(y_v), .x_in(x_v), .w_in(w_v),
        .sp_in(sp_r), .dp_in(dp_v), .b_in(b_v), .a_in(a_v),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .pc_out(pc_out), .pc_we(pc_we), .cc_out(cc_out), .cc_we(cc_we),
        .sp_out(sp_out), .sp_we(sp_we), .cycles_out(cycles_out), .ack(ack),
        .ack_src(ack_src), .sync_wait(sync_wait), .wai_pending(wai_pending)
    );

    int checks = 0, fails = 0, ack_cnt = 0, wr_cnt = 0, stall_cfg = 0, wait_cnt = 0;
    string cur_req = "R4";
    logic [23:0] exp_wr[$];
    logic [15:0] exp_rd[$];
    logic [46:0] exp_ack[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model and result monitor
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (wait_cnt < stall_cfg) wait_cnt++;
            else begin
                wait_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    wr_cnt++;
                    if (exp_wr.size() == 0)
                        chk(0, cur_req, "unexpected write", {mem_addr, mem_wdata}, 0);
                    else begin
                        logic [23:0] e;
                        e = exp_wr.pop_front();
                        chk({mem_addr, mem_wdata} == e, cur_req, "frame byte",
                            {mem_addr, mem_wdata}, e);
                    end
                end else begin
                    mem_rdata = ~mem_addr[7:0];
                    if (exp_rd.size() == 0)
                        chk(0, "R11", "unexpected read", mem_addr, 0);
                    else begin
                        logic [15:0] e;
                        e = exp_rd.pop_front();
                        chk(mem_addr == e, "R11", "vector address", mem_addr, e);
                    end
                end
            end
        end
        if (rst_n && ack) begin
            ack_cnt++;
            chk(pc_we && cc_we && sp_we, "R11", "load strobes", {pc_we, cc_we, sp_we}, 3'b111);
            if (exp_ack.size() == 0)
                chk(0, cur_req, "unexpected ack", ack_src, 0);
            else begin
                logic [46:0] e;
                e = exp_ack.pop_front();
                chk({ack_src, pc_out, cc_out, sp_out, cycles_out} == e, cur_req,
                    "src/pc/cc/sp/cycles", {ack_src, pc_out, cc_out, sp_out, cycles_out}, e);
            end
            cc_r = cc_out;
            sp_r = sp_out;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // driver: queue the expected frame, vector reads and completion
    task automatic expect_entry(input logic [1:0] src, input bit waited);
        logic full, ext;
        logic [15:0] sp, vec, vec1;
        logic [7:0] ccp, mask, ccn;
        logic [4:0] cyc;
        logic [7:0] bl[$];
        full = (src != 2'd2) || fast_full;
        ext  = ext_mode && full;
        vec  = (src == 2'd1) ? 16'hFFFC : (src == 2'd2) ? 16'hFFF6 : 16'hFFF8;
        vec1 = vec + 16'd1;
        mask = (src == 2'd3) ? 8'h10 : 8'h50;
        sp   = sp_r;
        if (waited) begin
            ccn = cc_r | mask;
            cyc = 5'd7;
        end else begin
            ccp = full ? (cc_r | 8'h80) : (cc_r & 8'h7F);
            bl.push_back(pc_v[7:0]); bl.push_back(pc_v[15:8]);
            if (full) begin
                bl.push_back(u_v[7:0]); bl.push_back(u_v[15:8]);
                bl.push_back(y_v[7:0]); bl.push_back(y_v[15:8]);
                bl.push_back(x_v[7:0]); bl.push_back(x_v[15:8]);
                bl.push_back(dp_v);
                if (ext) begin
                    bl.push_back(w_v[7:0]); bl.push_back(w_v[15:8]);
                end
                bl.push_back(b_v); bl.push_back(a_v);
            end
            bl.push_back(ccp);
            for (int i = 0; i < bl.size(); i++) begin
                sp = sp - 16'd1;
                exp_wr.push_back({sp, bl[i]});
            end
            ccn = ccp | mask;
            cyc = !full ? 5'd10 : (ext ? 5'd21 : 5'd19);
        end
        exp_rd.push_back(vec);
        exp_rd.push_back(vec1);
        exp_ack.push_back({src, ~vec[7:0], ~vec1[7:0], ccn, sp, cyc});
    endtask

    task automatic wait_ack(input int target, input string req);
        for (int i = 0; i < 400 && ack_cnt < target; i++) tick(1);
        chk(ack_cnt >= target, req, "entry completed", ack_cnt, target);
    endtask

    task automatic quiet(input int n, input int exp_cnt, input string req);
        tick(n);
        chk(ack_cnt == exp_cnt, req, "no entry taken", ack_cnt, exp_cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base;
        rst_n = 0; insn_boundary = 1; nmi_req = 0; fast_req = 0; norm_req = 0;
        sp_load = 0; sync_enter = 0; wai_enter = 0; ext_mode = 0; fast_full = 0;
        cc_r = 8'h50; sp_r = 16'h0400; mem_ack = 0; mem_rdata = 0;
        tick(5);
        rst_n = 1;
        tick(1);
        // reset state (R12 idle port)
        chk(!mem_req && !ack && !sync_wait && !wai_pending, "R12", "reset idle",
            {mem_req, ack, sync_wait, wai_pending}, 0);

        // R1: edge before arming and level held through arming are dropped
        nmi_req = 1; tick(5);
        sp_load = 1; tick(1); sp_load = 0;
        quiet(15, 0, "R1");
        chk(wr_cnt == 0, "R1", "no writes before arming", wr_cnt, 0);
        nmi_req = 0; tick(3);

        // R4/R5/R6: normal full entry
        cur_req = "R4"; cc_r = 8'h00;
        expect_entry(2'd3, 0);
        norm_req = 1; wait_ack(1, "R4"); norm_req = 0; tick(3);

        // R3: fast short entry, frame flag cleared in saved byte
        cur_req = "R3"; cc_r = 8'h80;
        expect_entry(2'd2, 0);
        fast_req = 1; wait_ack(2, "R3"); fast_req = 0; tick(3);

        // R2: fast wins over normal
        cur_req = "R2"; cc_r = 8'h00;
        expect_entry(2'd2, 0);
        fast_req = 1; norm_req = 1; wait_ack(3, "R2");
        quiet(10, 3, "R2");
        fast_req = 0; norm_req = 0; tick(3);

        // R2: masked fast lets normal through
        cc_r = 8'h40;
        expect_entry(2'd3, 0);
        fast_req = 1; norm_req = 1; wait_ack(4, "R2");
        fast_req = 0; norm_req = 0; tick(3);

        // R8: sync flag released by a masked request
        cc_r = 8'h50;
        sync_enter = 1; tick(1); sync_enter = 0; tick(1);
        chk(sync_wait == 1'b1, "R8", "sync set", sync_wait, 1);
        fast_req = 1; tick(2);
        chk(sync_wait == 1'b0, "R8", "sync cleared by masked request", sync_wait, 0);
        quiet(10, 4, "R2");
        fast_req = 0; tick(3);

        // R1: NMI edge under full masks, level hold adds nothing
        cur_req = "R1"; cc_r = 8'h50;
        expect_entry(2'd1, 0);
        nmi_req = 1; wait_ack(5, "R1");
        quiet(15, 5, "R1");
        nmi_req = 0; quiet(10, 5, "R1");

        // R7: wait-stacked entry
        cur_req = "R7"; cc_r = 8'h00;
        wai_enter = 1; tick(1); wai_enter = 0; tick(1);
        chk(wai_pending == 1'b1, "R7", "wait flag set", wai_pending, 1);
        base = wr_cnt;
        expect_entry(2'd3, 1);
        norm_req = 1; wait_ack(6, "R7"); norm_req = 0; tick(2);
        chk(wai_pending == 1'b0, "R7", "wait flag cleared", wai_pending, 0);
        chk(wr_cnt == base, "R7", "no frame writes", wr_cnt, base);

        // R9: extended frame with memory stalls (R12)
        cur_req = "R9"; stall_cfg = 2; ext_mode = 1; cc_r = 8'h00;
        expect_entry(2'd3, 0);
        norm_req = 1; wait_ack(7, "R9"); norm_req = 0; tick(3);

        // R10: fast entry forced to full save
        cur_req = "R10"; ext_mode = 0; fast_full = 1; cc_r = 8'h00;
        expect_entry(2'd2, 0);
        fast_req = 1; wait_ack(8, "R10"); fast_req = 0; tick(3);
        fast_full = 0; stall_cfg = 0;

        // R13: no start without a boundary
        cur_req = "R13"; insn_boundary = 0; cc_r = 8'h00;
        expect_entry(2'd3, 0);
        norm_req = 1;
        quiet(12, 8, "R13");
        insn_boundary = 1; wait_ack(9, "R13"); norm_req = 0; tick(3);

        chk(exp_wr.size() == 0 && exp_rd.size() == 0 && exp_ack.size() == 0, "R5",
            "scoreboard drained", exp_wr.size() + exp_rd.size() + exp_ack.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule